// File: doc/BRIEF.md
# Control Subcommand Handler

This block executes 16-bit control subcommands that a host writes into the two-byte control location of a battery monitor's register space. The register port decodes the two bytes and presents the assembled code with a one-cycle valid strobe. Each code is first checked against the current access mode. An accepted code then updates the status and access-mode flags, raises a one-cycle request towards the shutdown or reset logic, starts a timed pulse on the general-purpose output, or loads a 16-bit response word that the register port returns on the next read of the control location.

Two access modes exist. In the open mode every known code is executed. In the sealed mode the configuration, shutdown, seal, reset and soft-reset codes are refused. A refused or unknown code leaves every flag, the response word and the record of the previous code as they were. Leaving the sealed mode is handled elsewhere, so inside this block only a reset clears it.

Top module: `ctl_sub_handler`

## Requirements
- R1: After reset all status flags, the battery-detect flag, the response word, both request outputs and the pulse output are 0, and the sealed flag equals the RESET_SEALED parameter (default 0). The previous-code record is 0.
- R2: The response word is loaded one cycle after an accepted code, and only by these read codes: 0x0001 loads DEV_TYPE (default 0x0421), 0x0002 loads FW_VER (default 0x0109), 0x0004 loads DM_CODE (default 0x0048) and 0x0008 loads CHEM_ID (default 0x0128). Action codes leave the response word unchanged.
- R3: Code 0x0000 loads the status word. Its bit 0 is shutdown-enable, bit 1 is hibernate, bit 2 is config-update, bit 3 is sealed and bit 4 is battery-detect, and bits 15..5 are 0.
- R4: Code 0x0007 loads the last accepted code that came before it. Refused and unknown codes are never recorded.
- R5: Codes 0x000C and 0x000D set and clear the battery-detect flag when bie_cfg is 0. When bie_cfg is 1, the flag keeps its value.
- R6: Code 0x0011 sets the hibernate flag and code 0x0012 clears it.
- R7: Code 0x0013 sets the config-update flag and code 0x0042 clears it.
- R8: Code 0x001B sets shutdown-enable. Code 0x001C raises shutdown_req for exactly one cycle, but only if shutdown-enable was already set.
- R9: Code 0x0041 raises reset_req for exactly one cycle.
- R10: Code 0x0020 sets the sealed flag, and the flag stays set until reset. While sealed, codes 0x0013, 0x001B, 0x001C, 0x0020, 0x0041 and 0x0042 are refused, and codes 0x0000 to 0x0012 and 0x0023 still execute.
- R11: Code 0x0023 drives gpout_pulse high from the cycle after acceptance for PULSE_CYCLES cycles. The code is accepted while sealed. Accepting it again during a pulse restarts the full length, including in the last cycle of the pulse.
- R12: Any code outside the listed set changes no flag, no request, no response and no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe: a subcommand was written |
| cmd_code | input | 16 | Subcommand code |
| bie_cfg | input | 1 | Configuration bit: 1 means battery detection comes from the pin, so forcing is ignored |
| bat_det | output | 1 | Battery-detect flag |
| st_sealed | output | 1 | Sealed access mode |
| st_hibernate | output | 1 | Hibernate request flag |
| st_cfgup | output | 1 | Config-update mode flag |
| st_shutdown_en | output | 1 | Shutdown enabled |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle full-reset request |
| gpout_pulse | output | 1 | Timed output pulse |
| resp_data | output | 16 | Response word for the next control read |

## Verification
The pulse timer can expire in the same cycle that a new toggle code is accepted. The retrigger rule has to win that race, or the output drops for one cycle. The bench provokes this by issuing the second toggle so that it is captured on the edge where the remaining count goes from one to zero. It then judges the result at the output: the pulse must show no low cycle and must stay high for a full PULSE_CYCLES from the restart. A refused code can also coincide with a pending response, and the bench judges that by reading the previous-code record afterwards.

// File: rtl/ctl_sub_pkg.sv
package ctl_sub_pkg;

   localparam logic [15:0] C_STATUS  = 16'h0000;
   localparam logic [15:0] C_DEVTYPE = 16'h0001;
   localparam logic [15:0] C_FWVER   = 16'h0002;
   localparam logic [15:0] C_DMCODE  = 16'h0004;
   localparam logic [15:0] C_PREV    = 16'h0007;
   localparam logic [15:0] C_CHEM    = 16'h0008;
   localparam logic [15:0] C_BATINS  = 16'h000C;
   localparam logic [15:0] C_BATREM  = 16'h000D;
   localparam logic [15:0] C_HIBSET  = 16'h0011;
   localparam logic [15:0] C_HIBCLR  = 16'h0012;
   localparam logic [15:0] C_CFGSET  = 16'h0013;
   localparam logic [15:0] C_SDEN    = 16'h001B;
   localparam logic [15:0] C_SD      = 16'h001C;
   localparam logic [15:0] C_SEAL    = 16'h0020;
   localparam logic [15:0] C_TOGGLE  = 16'h0023;
   localparam logic [15:0] C_RESET   = 16'h0041;
   localparam logic [15:0] C_SOFTRST = 16'h0042;

   typedef enum logic [4:0] {
      K_NONE, K_STATUS, K_DEVTYPE, K_FWVER, K_DMCODE, K_PREV, K_CHEM,
      K_BATINS, K_BATREM, K_HIBSET, K_HIBCLR, K_CFGSET, K_SOFTRST,
      K_SDEN, K_SD, K_SEAL, K_TOGGLE, K_RESET
   } sub_kind_t;

   // Status word layout, bit 4 down to bit 0.
   typedef struct packed {
      logic bat_det;
      logic sealed;
      logic cfgup;
      logic hib;
      logic sd_en;
   } sub_stat_t;

   localparam int STAT_W = $bits(sub_stat_t);

   function automatic logic open_only(sub_kind_t k);
      return (k == K_CFGSET) || (k == K_SOFTRST) || (k == K_SDEN) ||
             (k == K_SD) || (k == K_SEAL) || (k == K_RESET);
   endfunction

endpackage

// File: rtl/ctl_sub_decode.sv
module ctl_sub_decode
   import ctl_sub_pkg::*;
#(
   parameter int CODE_W = 16
)(
   input  logic [CODE_W-1:0] code,
   input  logic              valid,
   input  logic              sealed,
   output sub_kind_t         kind,
   output logic              accept
);

   always_comb begin
      case (code)
         C_STATUS:  kind = K_STATUS;
         C_DEVTYPE: kind = K_DEVTYPE;
         C_FWVER:   kind = K_FWVER;
         C_DMCODE:  kind = K_DMCODE;
         C_PREV:    kind = K_PREV;
         C_CHEM:    kind = K_CHEM;
         C_BATINS:  kind = K_BATINS;
         C_BATREM:  kind = K_BATREM;
         C_HIBSET:  kind = K_HIBSET;
         C_HIBCLR:  kind = K_HIBCLR;
         C_CFGSET:  kind = K_CFGSET;
         C_SDEN:    kind = K_SDEN;
         C_SD:      kind = K_SD;
         C_SEAL:    kind = K_SEAL;
         C_TOGGLE:  kind = K_TOGGLE;
         C_RESET:   kind = K_RESET;
         C_SOFTRST: kind = K_SOFTRST;
         default:   kind = K_NONE;
      endcase
   end

   // Sealed mode refuses the open-only group.
   assign accept = valid && (kind != K_NONE) && !(sealed && open_only(kind));

endmodule

// File: rtl/ctl_sub_state.sv
module ctl_sub_state
   import ctl_sub_pkg::*;
#(
   parameter bit RESET_SEALED = 1'b0
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      accept,
   input  sub_kind_t kind,
   input  logic      bie_cfg,
   output sub_stat_t stat,
   output logic      sd_req,
   output logic      rst_req
);

   localparam sub_stat_t STAT_INIT = '{bat_det: 1'b0, sealed: RESET_SEALED,
                                      cfgup: 1'b0, hib: 1'b0, sd_en: 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat    <= STAT_INIT;
         sd_req  <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         sd_req  <= 1'b0;
         rst_req <= 1'b0;
         if (accept) begin
            case (kind)
               K_BATINS:  if (!bie_cfg) stat.bat_det <= 1'b1;
               K_BATREM:  if (!bie_cfg) stat.bat_det <= 1'b0;
               K_HIBSET:  stat.hib    <= 1'b1;
               K_HIBCLR:  stat.hib    <= 1'b0;
               K_CFGSET:  stat.cfgup  <= 1'b1;
               K_SOFTRST: stat.cfgup  <= 1'b0;
               K_SDEN:    stat.sd_en  <= 1'b1;
               K_SD:      if (stat.sd_en) sd_req <= 1'b1;
               K_SEAL:    stat.sealed <= 1'b1;
               K_RESET:   rst_req     <= 1'b1;
               default:   ;
            endcase
         end
      end
   end

endmodule

// File: rtl/ctl_sub_resp.sv
module ctl_sub_resp
   import ctl_sub_pkg::*;
#(
   parameter int          DATA_W   = 16,
   parameter logic [15:0] DEV_TYPE = 16'h0421,
   parameter logic [15:0] FW_VER   = 16'h0109,
   parameter logic [15:0] DM_CODE  = 16'h0048,
   parameter logic [15:0] CHEM_ID  = 16'h0128
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  sub_kind_t         kind,
   input  logic [DATA_W-1:0] code,
   input  sub_stat_t         stat,
   output logic [DATA_W-1:0] resp
);

   localparam int PAD_W = DATA_W - STAT_W;

   logic [DATA_W-1:0] prev_q;
   logic [DATA_W-1:0] stat_word;

   generate
      if (PAD_W > 0) begin : g_pad
         assign stat_word = {{PAD_W{1'b0}}, stat};
      end else begin : g_nopad
         assign stat_word = stat;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         resp   <= '0;
      end else if (accept) begin
         prev_q <= code;
         case (kind)
            K_STATUS:  resp <= stat_word;
            K_DEVTYPE: resp <= DEV_TYPE;
            K_FWVER:   resp <= FW_VER;
            K_DMCODE:  resp <= DM_CODE;
            K_CHEM:    resp <= CHEM_ID;
            K_PREV:    resp <= prev_q;
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/ctl_sub_pulse.sv
module ctl_sub_pulse #(
   parameter int PULSE_CYCLES = 1000,
   parameter bit RETRIGGER    = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pulse
);

   localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             fire;

   generate
      if (RETRIGGER) begin : g_restart
         assign fire = start;
      end else begin : g_hold
         assign fire = start && (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (fire)         cnt_q <= CNT_W'(PULSE_CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign pulse = (cnt_q != '0);

endmodule

// File: rtl/ctl_sub_handler.sv
module ctl_sub_handler
   import ctl_sub_pkg::*;
#(
   parameter int          CODE_W       = 16,
   parameter int          PULSE_CYCLES = 1000,
   parameter bit          RETRIGGER    = 1'b1,
   parameter bit          RESET_SEALED = 1'b0,
   parameter logic [15:0] DEV_TYPE     = 16'h0421,
   parameter logic [15:0] FW_VER       = 16'h0109,
   parameter logic [15:0] DM_CODE      = 16'h0048,
   parameter logic [15:0] CHEM_ID      = 16'h0128
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              bie_cfg,
   output logic              bat_det,
   output logic              st_sealed,
   output logic              st_hibernate,
   output logic              st_cfgup,
   output logic              st_shutdown_en,
   output logic              shutdown_req,
   output logic              reset_req,
   output logic              gpout_pulse,
   output logic [CODE_W-1:0] resp_data
);

   generate
      if (CODE_W != 16) begin : g_bad_width
         $error("ctl_sub_handler: CODE_W must be 16");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("ctl_sub_handler: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   sub_kind_t kind;
   logic      accept;
   sub_stat_t stat;

   ctl_sub_decode #(.CODE_W(CODE_W)) u_dec (
      .code   (cmd_code),
      .valid  (cmd_valid),
      .sealed (stat.sealed),
      .kind   (kind),
      .accept (accept)
   );

   ctl_sub_state #(.RESET_SEALED(RESET_SEALED)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .kind    (kind),
      .bie_cfg (bie_cfg),
      .stat    (stat),
      .sd_req  (shutdown_req),
      .rst_req (reset_req)
   );

   ctl_sub_resp #(
      .DATA_W   (CODE_W),
      .DEV_TYPE (DEV_TYPE),
      .FW_VER   (FW_VER),
      .DM_CODE  (DM_CODE),
      .CHEM_ID  (CHEM_ID)
   ) u_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .kind   (kind),
      .code   (cmd_code),
      .stat   (stat),
      .resp   (resp_data)
   );

   ctl_sub_pulse #(
      .PULSE_CYCLES (PULSE_CYCLES),
      .RETRIGGER    (RETRIGGER)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept && (kind == K_TOGGLE)),
      .pulse (gpout_pulse)
   );

   assign bat_det        = stat.bat_det;
   assign st_sealed      = stat.sealed;
   assign st_hibernate   = stat.hib;
   assign st_cfgup       = stat.cfgup;
   assign st_shutdown_en = stat.sd_en;

endmodule

// File: rtl/ctl_sub_handler_chk.sv
module ctl_sub_handler_chk #(
   parameter int PULSE_CYCLES = 1000,
   parameter bit RETRIGGER    = 1'b1
)(
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [15:0] cmd_code,
   input logic        bie_cfg,
   input logic        bat_det,
   input logic        st_sealed,
   input logic        st_hibernate,
   input logic        st_cfgup,
   input logic        st_shutdown_en,
   input logic        shutdown_req,
   input logic        reset_req,
   input logic        gpout_pulse,
   input logic [15:0] resp_data
);

   localparam int SW = $clog2(PULSE_CYCLES + 2);

   function automatic logic is_known(logic [15:0] c);
      case (c)
         16'h0000, 16'h0001, 16'h0002, 16'h0004, 16'h0007, 16'h0008,
         16'h000C, 16'h000D, 16'h0011, 16'h0012, 16'h0013, 16'h001B,
         16'h001C, 16'h0020, 16'h0023, 16'h0041, 16'h0042: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   logic toggle_in;
   assign toggle_in = cmd_valid && (cmd_code == 16'h0023);

   // Cycles since the last captured toggle, saturating.
   logic [SW-1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                since_q <= '0;
      else if (toggle_in)                        since_q <= SW'(1);
      else if (since_q != '0 &&
               since_q != SW'(PULSE_CYCLES + 1)) since_q <= since_q + 1'b1;
   end

   p_hib_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == 16'h0011 |=> st_hibernate);

   p_bie_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && bie_cfg |=> $stable(bat_det));

   p_sd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> st_shutdown_en);

   p_rst_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(cmd_valid && cmd_code == 16'h0041 && !st_sealed));

   p_seal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_sealed |=> st_sealed);

   p_seal_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_sealed && !st_cfgup && cmd_valid && cmd_code == 16'h0013 |=> !st_cfgup);

   p_pulse_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gpout_pulse) |-> $past(toggle_in));

   p_pulse_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
      gpout_pulse && RETRIGGER |-> since_q != '0 && since_q <= SW'(PULSE_CYCLES));

   p_unknown_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !is_known(cmd_code) |=> $stable(resp_data) && $stable(st_hibernate)
                                         && $stable(st_cfgup) && $stable(bat_det));

endmodule

bind ctl_sub_handler ctl_sub_handler_chk #(
   .PULSE_CYCLES (PULSE_CYCLES),
   .RETRIGGER    (RETRIGGER)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid      (cmd_valid),
   .cmd_code       (cmd_code),
   .bie_cfg        (bie_cfg),
   .bat_det        (bat_det),
   .st_sealed      (st_sealed),
   .st_hibernate   (st_hibernate),
   .st_cfgup       (st_cfgup),
   .st_shutdown_en (st_shutdown_en),
   .shutdown_req   (shutdown_req),
   .reset_req      (reset_req),
   .gpout_pulse    (gpout_pulse),
   .resp_data      (resp_data)
);

// File: tb/ctl_sub_handler_test.sv
module ctl_sub_handler_test;

   localparam int CLK_PERIOD = 10;
   localparam int NPULSE     = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_code = '0;
   logic        bie_cfg = 1'b0;
   logic        bat_det, st_sealed, st_hibernate, st_cfgup, st_shutdown_en;
   logic        shutdown_req, reset_req, gpout_pulse;
   logic [15:0] resp_data;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctl_sub_handler #(.PULSE_CYCLES(NPULSE)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .bie_cfg(bie_cfg), .bat_det(bat_det), .st_sealed(st_sealed),
      .st_hibernate(st_hibernate), .st_cfgup(st_cfgup),
      .st_shutdown_en(st_shutdown_en), .shutdown_req(shutdown_req),
      .reset_req(reset_req), .gpout_pulse(gpout_pulse), .resp_data(resp_data)
   );

   // code in upper half, expected response in lower half
   localparam logic [31:0] VEC [6] = '{
      32'h0001_0421, 32'h0099_0421, 32'h0002_0109,
      32'h0004_0048, 32'h0008_0128, 32'h00FF_0128
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Caller stands at a negedge; returns at the negedge after capture.
   task automatic issue(input logic [15:0] c);
      cmd_valid = 1'b1;
      cmd_code  = c;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = 16'hFFFF;
   endtask

   function automatic logic [15:0] stat_now();
      return {11'd0, bat_det, st_sealed, st_cfgup, st_hibernate, st_shutdown_en};
   endfunction

   task automatic count_high(output int n);
      n = 0;
      while (gpout_pulse && n < NPULSE + 5) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", stat_now(), 16'h0000);
      chk("R1 resp", resp_data, 16'h0000);
      chk("R1 outputs", {13'd0, shutdown_req, reset_req, gpout_pulse}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 previous record starts at 0
      issue(16'h0007);
      chk("R4 prev after reset", resp_data, 16'h0000);

      // R2 / R12 table walk
      foreach (VEC[i]) begin
         issue(VEC[i][31:16]);
         chk((VEC[i][31:16] == 16'h0099 || VEC[i][31:16] == 16'h00FF) ?
             "R12 unknown resp" : "R2 read resp", resp_data, VEC[i][15:0]);
      end
      issue(16'h0007);
      chk("R4 prev skips unknown", resp_data, 16'h0008);

      // R5 battery-detect forcing
      issue(16'h000C);
      chk("R5 insert", {15'd0, bat_det}, 16'h0001);
      chk("R2 action keeps resp", resp_data, 16'h0008);
      bie_cfg = 1'b1;
      issue(16'h000D);
      chk("R5 remove ignored bie", {15'd0, bat_det}, 16'h0001);
      bie_cfg = 1'b0;
      issue(16'h000D);
      chk("R5 remove", {15'd0, bat_det}, 16'h0000);
      issue(16'h000C);

      // R6 / R3
      issue(16'h0011);
      chk("R6 hib set", {15'd0, st_hibernate}, 16'h0001);
      issue(16'h0000);
      chk("R3 status word", resp_data, 16'h0012);
      issue(16'h0012);
      chk("R6 hib clear", {15'd0, st_hibernate}, 16'h0000);

      // R7
      issue(16'h0013);
      chk("R7 cfg set", {15'd0, st_cfgup}, 16'h0001);
      issue(16'h0042);
      chk("R7 cfg clear", {15'd0, st_cfgup}, 16'h0000);
      issue(16'h0013);

      // R8
      issue(16'h001C);
      chk("R8 no req without enable", {15'd0, shutdown_req}, 16'h0000);
      issue(16'h001B);
      chk("R8 enable", {15'd0, st_shutdown_en}, 16'h0001);
      issue(16'h001C);
      chk("R8 req", {15'd0, shutdown_req}, 16'h0001);
      @(negedge clk);
      chk("R8 req one cycle", {15'd0, shutdown_req}, 16'h0000);

      // R9
      issue(16'h0041);
      chk("R9 reset req", {15'd0, reset_req}, 16'h0001);
      @(negedge clk);
      chk("R9 reset req one cycle", {15'd0, reset_req}, 16'h0000);

      // R11 pulse length and same-cycle retrigger at expiry
      issue(16'h0023);
      count_high(n);
      chk("R11 pulse length", 16'(n), 16'(NPULSE));
      issue(16'h0023);
      repeat (NPULSE - 1) @(negedge clk);
      chk("R11 still high last cycle", {15'd0, gpout_pulse}, 16'h0001);
      issue(16'h0023);
      count_high(n);
      chk("R11 retrigger at expiry", 16'(n), 16'(NPULSE));

      // R10 sealed mode
      issue(16'h0020);
      chk("R10 sealed set", {15'd0, st_sealed}, 16'h0001);
      issue(16'h0000);
      chk("R3 status sealed", resp_data, 16'h001D);
      issue(16'h0042);
      chk("R10 soft reset refused", {15'd0, st_cfgup}, 16'h0001);
      chk("R10 refused keeps resp", resp_data, 16'h001D);
      issue(16'h0007);
      chk("R10 refused not recorded", resp_data, 16'h0000);
      issue(16'h0041);
      chk("R10 reset refused", {15'd0, reset_req}, 16'h0000);
      issue(16'h001C);
      chk("R10 shutdown refused", {15'd0, shutdown_req}, 16'h0000);
      issue(16'h0011);
      chk("R10 hib allowed sealed", {15'd0, st_hibernate}, 16'h0001);
      issue(16'h0023);
      chk("R11 toggle allowed sealed", {15'd0, gpout_pulse}, 16'h0001);
      repeat (NPULSE + 2) @(negedge clk);
      chk("R11 pulse ended", {15'd0, gpout_pulse}, 16'h0000);

      // R10 sealed clears only by reset, R1 again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 sealed cleared by reset", stat_now(), 16'h0000);
      chk("R1 resp after reset", resp_data, 16'h0000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule